// File: doc/BRIEF.md
# Truncated Hamming-Distance Weight Accumulator

This block takes the two halves of a bitwise difference vector between a stored code word and a freshly encoded one. The data half arrives early and the parity half arrives late. The block reports how many of the bits are set, but only as far as a configurable limit `RMAX`. Above that limit, one flag says "too many". The exact value there is of no interest to a range decoder placed downstream.

The count is formed from half adders only. Each half-adder output wire keeps a power-of-two weight, and no full adder is used.

- **First level.** Each half runs through its own butterfly network of half adders. In that network, output wire `i` carries weight `2^popcount(i)`.
  - Wires heavier than `PMAX` go to an OR tree. `PMAX` is the largest power of two not above `RMAX+1`.
  - The lighter wires are sorted by weight.
- **Second level.** For every weight level up to `PMAX`, one butterfly gathers the wires of that weight from both halves.
  - Its outputs that would exceed `PMAX` join the OR tree.
  - The few remaining weighted bits form a small binary count.
- **Result.** The OR flags and the small count together give the truncated distance.

The block is purely combinational. It has no clock, no reset and no storage.

Top module: `hd_range_acc`

## Requirements
- R1: `dist_over` is 1 exactly when the number of set bits across `dat_diff` and `par_diff` together is greater than `RMAX`.
- R2: When `dist_over` is 0, `dist_cnt` equals the number of set bits across both inputs, as an unsigned binary value.
- R3: When `dist_over` is 1, `dist_cnt` reads 0.
- R4: With both inputs all zero, `dist_cnt` is 0 and `dist_over` is 0.
- R5: A set bit counts the same whatever its position, whether it lies in the data half or in the parity half. Every single-bit input gives a count of 1.
- R6: The outputs follow any change of the inputs without any clock edge, within the same cycle in which the inputs change.
- R7: At the boundary, exactly `RMAX` set bits give `dist_over` = 0 with `dist_cnt` = `RMAX`. Exactly `RMAX+1` set bits give `dist_over` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dat_diff | input | DATA_W | Difference bits of the data half (early arrival) |
| par_diff | input | PAR_W | Difference bits of the parity half (late arrival) |
| dist_cnt | output | $clog2(RMAX+2) | Number of set bits when within range, else 0 |
| dist_over | output | 1 | Set when the number of set bits exceeds RMAX |

## Verification
Both results are due in the cycle the inputs change: zero cycles of delay, since no register lies on any path. The bench drives new inputs just after a rising edge and samples `dist_cnt` and `dist_over` at the following falling edge. For R6, it also changes the inputs at a falling edge and samples a few nanoseconds later, before the next rising edge. Two small configurations are swept over all 256 patterns of 8 bits. Two full-width configurations receive patterns with controlled numbers of set bits, so that the `RMAX` boundary is hit often.

// File: rtl/hd_pkg.sv
package hd_pkg;

    // number of set bits in an integer index (weight exponent of a butterfly wire)
    function automatic int pc_of(input int v);
        int c;
        c = 0;
        for (int b = 0; b < 31; b++) begin
            c = c + ((v >> b) & 1);
        end
        return c;
    endfunction

    // smallest power of two not below n
    function automatic int pad_pow2(input int n);
        int p;
        p = 1;
        for (int b = 0; b < 31; b++) begin
            if (p < n) p = p * 2;
        end
        return p;
    endfunction

    // exponent of the largest power of two not above rmax+1
    function automatic int log_pmax(input int rmax);
        return $clog2(rmax + 2) - 1;
    endfunction

endpackage

// File: rtl/hd_bfly.sv
module hd_bfly
    import hd_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0]              vec_i,
    output logic [pad_pow2(N)-1:0]    wire_o
);
    localparam int NP = pad_pow2(N);
    localparam int LG = $clog2(NP);

    logic [NP-1:0] cur;
    logic [NP-1:0] nxt;

    // stages of half adders; pair i with i+2^s, sum stays, carry moves up
    always_comb begin
        cur = '0;
        cur[N-1:0] = vec_i;
        nxt = cur;
        for (int s = 0; s < LG; s++) begin
            nxt = cur;
            for (int i = 0; i < NP; i++) begin
                if (((i >> s) & 1) == 0) begin
                    nxt[i]            = cur[i] ^ cur[i + (1 << s)];
                    nxt[i + (1 << s)] = cur[i] & cur[i + (1 << s)];
                end
            end
            cur = nxt;
        end
        wire_o = cur;
    end

    // weighted wires must reproduce the population count of the input
    int wsum;
    always_comb begin
        wsum = 0;
        for (int i = 0; i < NP; i++) begin
            if (wire_o[i]) wsum = wsum + (1 << pc_of(i));
        end
        assert_weight_sum_R2: assert (wsum == $countones(vec_i));
    end

endmodule

// File: rtl/hd_split.sv
module hd_split
    import hd_pkg::*;
#(
    parameter int NP   = 8,
    parameter int BASE = 0,
    parameter int LOGP = 1,
    parameter int SW   = 4
) (
    input  logic [NP-1:0] wire_i,
    output logic          over_o,
    output logic [SW-1:0] sum_o
);
    // wires heavier than 2^LOGP feed the OR tree; the rest add up as weights
    always_comb begin
        over_o = 1'b0;
        sum_o  = '0;
        for (int i = 0; i < NP; i++) begin
            if (wire_i[i]) begin
                if (pc_of(i) + BASE > LOGP) over_o = 1'b1;
                else sum_o = sum_o + SW'(1 << (pc_of(i) + BASE));
            end
        end
    end

endmodule

// File: rtl/hd_range_acc.sv
module hd_range_acc
    import hd_pkg::*;
#(
    parameter int DATA_W = 33,
    parameter int PAR_W  = 7,
    parameter int RMAX   = 2
) (
    input  logic [DATA_W-1:0]          dat_diff,
    input  logic [PAR_W-1:0]           par_diff,
    output logic [$clog2(RMAX+2)-1:0]  dist_cnt,
    output logic                       dist_over
);
    localparam int LOGP  = log_pmax(RMAX);
    localparam int NLV   = LOGP + 1;
    localparam int NPD   = pad_pow2(DATA_W);
    localparam int NPP   = pad_pow2(PAR_W);
    localparam int NPC   = NPD + NPP;
    localparam int NPC2  = pad_pow2(NPC);
    localparam int SW    = $clog2(DATA_W + PAR_W + 1) + 1;
    localparam int CNT_W = $clog2(RMAX + 2);

    logic [NPD-1:0] wd;
    logic [NPP-1:0] wp;
    logic           ov_d, ov_p;
    logic [SW-1:0]  lo_d, lo_p;
    logic [NLV-1:0] lv_over;
    logic [SW-1:0]  lv_sum [NLV];
    logic [SW-1:0]  tot;
    logic           hi_any;

    // first level: one butterfly per half
    hd_bfly #(.N(DATA_W)) u_bd (.vec_i(dat_diff), .wire_o(wd));
    hd_bfly #(.N(PAR_W))  u_bp (.vec_i(par_diff), .wire_o(wp));

    hd_split #(.NP(NPD), .BASE(0), .LOGP(LOGP), .SW(SW))
        u_sd (.wire_i(wd), .over_o(ov_d), .sum_o(lo_d));
    hd_split #(.NP(NPP), .BASE(0), .LOGP(LOGP), .SW(SW))
        u_sp (.wire_i(wp), .over_o(ov_p), .sum_o(lo_p));

    // second level: one accumulator per weight 2^j, j = 0..LOGP
    genvar j;
    for (j = 0; j < NLV; j++) begin : g_lv
        logic [NPC-1:0]  gather;
        logic [NPC2-1:0] w2;

        always_comb begin
            gather = '0;
            for (int i = 0; i < NPD; i++) gather[i]       = wd[i] & (pc_of(i) == j);
            for (int i = 0; i < NPP; i++) gather[NPD + i] = wp[i] & (pc_of(i) == j);
        end

        hd_bfly #(.N(NPC)) u_b2 (.vec_i(gather), .wire_o(w2));
        hd_split #(.NP(NPC2), .BASE(j), .LOGP(LOGP), .SW(SW))
            u_s2 (.wire_i(w2), .over_o(lv_over[j]), .sum_o(lv_sum[j]));
    end

    // decision: OR tree of heavy wires plus small count of light ones
    always_comb begin
        tot = '0;
        for (int k = 0; k < NLV; k++) tot = tot + lv_sum[k];
        hi_any    = ov_d | ov_p | (|lv_over);
        dist_over = hi_any | (int'(tot) > RMAX);
        dist_cnt  = dist_over ? '0 : CNT_W'(tot);
    end

    // guards
    always_comb begin
        if (!(|lv_over)) begin
            assert_low_conserve_R2: assert (int'(lo_d) + int'(lo_p) == int'(tot));
        end
        assert_first_hi_R1: assert (!(ov_d | ov_p) || dist_over);
        assert_over_flag_R1: assert (dist_over == ($countones({par_diff, dat_diff}) > RMAX));
        if (!dist_over) begin
            assert_exact_count_R2: assert (int'(dist_cnt) == $countones({par_diff, dat_diff}));
        end
    end

endmodule

// File: tb/sim_hd_range_acc.sv
`timescale 1ns/1ps
module sim_hd_range_acc;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 0;

    // small configurations: 8 bits total
    logic [3:0]  d0; logic [3:0] p0; logic [1:0] c0; logic o0;
    logic [4:0]  d1; logic [2:0] p1; logic [2:0] c1; logic o1;
    // full width
    logic [32:0] d2; logic [6:0] p2; logic [1:0] c2; logic o2;
    logic [32:0] d3; logic [6:0] p3; logic [2:0] c3; logic o3;

    hd_range_acc #(.DATA_W(4),  .PAR_W(4), .RMAX(2)) u0 (.dat_diff(d0), .par_diff(p0), .dist_cnt(c0), .dist_over(o0));
    hd_range_acc #(.DATA_W(5),  .PAR_W(3), .RMAX(6)) u1 (.dat_diff(d1), .par_diff(p1), .dist_cnt(c1), .dist_over(o1));
    hd_range_acc #(.DATA_W(33), .PAR_W(7), .RMAX(2)) u2 (.dat_diff(d2), .par_diff(p2), .dist_cnt(c2), .dist_over(o2));
    hd_range_acc #(.DATA_W(33), .PAR_W(7), .RMAX(5)) u3 (.dat_diff(d3), .par_diff(p3), .dist_cnt(c3), .dist_over(o3));

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic judge(input string who, input int ones, input int rmax, input int cnt, input logic ov);
        chk("R1", {who, " over"}, int'(ov), int'(ones > rmax));
        if (ones > rmax) chk("R3", {who, " cnt"}, cnt, 0);
        else             chk("R2", {who, " cnt"}, cnt, ones);
    endtask

    task automatic apply_small(input logic [7:0] v);
        @(posedge clk);
        d0 = v[3:0]; p0 = v[7:4];
        d1 = v[4:0]; p1 = v[7:5];
        @(negedge clk);
        judge("u0", $countones(v), 2, int'(c0), o0);
        judge("u1", $countones(v), 6, int'(c1), o1);
    endtask

    task automatic apply_wide(input logic [39:0] v);
        @(posedge clk);
        d2 = v[32:0]; p2 = v[39:33];
        d3 = v[32:0]; p3 = v[39:33];
        @(negedge clk);
        judge("u2", $countones(v), 2, int'(c2), o2);
        judge("u3", $countones(v), 5, int'(c3), o3);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [39:0] v;
        d0 = '0; p0 = '0; d1 = '0; p1 = '0;
        d2 = '0; p2 = '0; d3 = '0; p3 = '0;

        // R4: idle, all-zero inputs
        @(negedge clk);
        chk("R4", "u0 cnt zero", int'(c0), 0);
        chk("R4", "u0 over zero", int'(o0), 0);
        chk("R4", "u2 cnt zero", int'(c2), 0);
        chk("R4", "u2 over zero", int'(o2), 0);

        // R5: each single position, in data and in parity halves
        for (int b = 0; b < 8; b++) begin
            @(posedge clk);
            d0 = 4'((8'd1 << b)); p0 = 4'((8'd1 << b) >> 4);
            @(negedge clk);
            chk("R5", "u0 single bit cnt", int'(c0), 1);
        end
        for (int b = 0; b < 40; b++) begin
            apply_wide(40'd1 << b);
            chk("R5", "u3 single bit cnt", int'(c3), 1);
        end

        // R1 R2 R3: exhaustive 8-bit sweep
        for (int k = 0; k < 256; k++) apply_small(8'(k));

        // R7: boundaries, split across halves
        apply_wide(40'h80_0000_0001);
        chk("R7", "u2 at RMAX cnt", int'(c2), 2);
        chk("R7", "u2 at RMAX over", int'(o2), 0);
        apply_wide(40'h80_0000_0003);
        chk("R7", "u2 at RMAX+1 over", int'(o2), 1);
        apply_wide(40'hC0_0000_0007);
        chk("R7", "u3 at RMAX cnt", int'(c3), 5);
        chk("R7", "u3 at RMAX over", int'(o3), 0);
        apply_wide(40'hC0_0001_0007);
        chk("R7", "u3 at RMAX+1 over", int'(o3), 1);
        apply_small(8'b0100_0011);
        chk("R7", "u1 below RMAX cnt", int'(c1), 3);
        apply_small(8'b1110_0111);
        chk("R7", "u1 at RMAX cnt", int'(c1), 6);
        chk("R7", "u1 at RMAX over", int'(o1), 0);
        apply_small(8'b1110_1111);
        chk("R7", "u1 at RMAX+1 over", int'(o1), 1);

        // R6: change mid-cycle, sample before the next rising edge
        @(negedge clk);
        d0 = 4'b0011; p0 = 4'b0000;
        #3;
        chk("R6", "u0 cnt without edge", int'(c0), 2);
        d0 = 4'b0111;
        #3;
        chk("R6", "u0 over without edge", int'(o0), 1);

        // wide patterns with controlled density
        for (int t = 0; t < 2500; t++) begin
            v = '0;
            repeat ($urandom_range(9, 0)) v[$urandom_range(39, 0)] = 1'b1;
            apply_wide(v);
        end
        for (int t = 0; t < 300; t++) begin
            v = {$urandom, $urandom};
            apply_wide(v);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule